// File: doc/BRIEF.md
# Double-Buffered SPI Master Shifter

This block is a byte-wide SPI master that moves one byte out on MOSI while it gathers one byte from MISO. Its bit clock is the system clock divided by two, so a bit lasts two `clk` cycles. Each bit has an early half and a late half. MOSI changes only where one bit meets the next. MISO is sampled at the middle of the bit. Clock polarity and phase come from two plain pins and give the four usual SPI modes.

Data enters through a valid/ready transmit stream that feeds a one-entry buffer in front of the shifter. `tx_ready` is high only while the block is enabled and the buffer is empty. A byte is taken on any clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the sender must hold its byte and wait; a valid it drops during that time is lost. If a byte sits in the buffer when the current byte ends, the next byte follows with no idle bit.

Received bytes leave through a valid/ready stream backed by a one-entry buffer. `rx_valid` stays high until a handshake with `rx_ready` takes the byte. The receive side never stalls the link: a new byte overwrites an unread one. The `spi_done` status flag rises with every received byte and is cleared by a `stat_rd` pulse. Dropping `enable` returns the lines and all flags to idle. The shifter, the transmit data and the receive data are kept.

Top module: `spi_master_dbuf`

## Requirements
- R1: While `enable` is low (after the first clock edge), `sclk` equals `cpol`, `tx_ready`, `rx_valid` and `spi_done` are 0, and `mosi` shows bit W-1 of the shifter when `lsb_first`=0 or bit 0 when `lsb_first`=1. After reset the shifter holds 0.
- R2: The bit clock divider is held at its late-half state while disabled. It enters the early half on the first clock edge with `enable` high and then alternates on every edge, so one bit takes exactly two `clk` cycles.
- R3: `sclk` equals `cpol` when no byte is in flight. During a bit it is inverted from `cpol` in the late half when `cpha`=0, and in the early half when `cpha`=1.
- R4: `mosi` changes only on the edge that starts a bit. Bits go out MSb first when `lsb_first`=0 and LSb first when `lsb_first`=1.
- R5: `tx_ready` is `enable` AND (transmit buffer empty). After a handshake, `tx_ready` is 0 on the next cycle. With no transfer running, the buffered byte enters the shifter on the next bit-start edge, and `tx_ready` returns to 1 on the cycle after that.
- R6: If a byte is buffered at least one `clk` cycle before the last bit of the current byte ends, it starts on that bit-start edge with no idle cycle. Consecutive received bytes then come exactly 2*W clocks apart.
- R7: MISO is sampled on the mid-bit edge into the same bit positions as the transmitted order. After W bits, the byte appears on `rx_data` with `rx_valid`=1. A handshake (`rx_valid` and `rx_ready`) clears `rx_valid` unless another byte completes on the same edge.
- R8: `spi_done` rises on the same edge as `rx_valid` for each byte and is cleared by `stat_rd`; a completing byte on the same edge wins.
- R9: A `tx_valid` presented while `tx_ready` is 0 is ignored: the buffered byte is not replaced and no extra byte is sent.
- R10: Disabling clears the flags and the transfer state and idles `sclk`. `rx_data` and the shifter contents (seen on `mosi`) survive a disable and re-enable.
- R11: If no byte is buffered when a byte ends, `sclk` returns to idle and `mosi` keeps the last transmitted bit until a new byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; bit rate is half of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the block; low returns it to idle |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | 0: `sclk` active in late half; 1: in early half |
| lsb_first | input | 1 | 1: LSb first, 0: MSb first |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | W | Transmit byte |
| tx_ready | output | 1 | Transmit buffer empty and block enabled |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | W | Last received byte |
| stat_rd | input | 1 | Status read pulse; clears `spi_done` |
| spi_done | output | 1 | A byte has completed since the last status read |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default width W=8. This keeps the bit counter at three bits and a chained pair of bytes at 16 clocks, so all four modes and both bit orders fit in short runs. Loopback from MOSI to MISO makes each received byte a direct check of the bit order sent. Random MISO bits, run against a behavioural model, cover sampling in every mode.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  // Half of the current bit period; the early half follows a bit-start edge.
  typedef enum logic {
    HALF_LATE  = 1'b0,
    HALF_EARLY = 1'b1
  } half_t;
endpackage

// File: rtl/spi_bitclk.sv
module spi_bitclk
  import spi_dbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  output half_t half_q,
  output logic  boundary,
  output logic  midpoint
);
  // R2: held in late half while disabled, free running divide-by-two otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     half_q <= HALF_LATE;
    else if (!en)   half_q <= HALF_LATE;
    else            half_q <= (half_q == HALF_EARLY) ? HALF_LATE : HALF_EARLY;
  end

  assign boundary = en && (half_q == HALF_LATE);
  assign midpoint = en && (half_q == HALF_EARLY);
endmodule

// File: rtl/spi_xfer_core.sv
module spi_xfer_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         boundary,
  input  logic         midpoint,
  input  logic         lsb_first,
  input  logic         miso,
  input  logic         tx_full,
  input  logic [W-1:0] tx_byte,
  output logic         busy,
  output logic         take,
  output logic         finish,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [W-1:0]  rx_sh;
  logic          last;
  logic          wrap;

  assign last   = busy && (cnt == LAST_IDX);
  assign wrap   = boundary && (!busy || last);
  assign take   = wrap && tx_full;      // R5/R6: load on bit-start edge
  assign finish = boundary && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (wrap) begin
      busy <= tx_full;
      cnt  <= '0;
    end else if (boundary && busy) begin
      cnt  <= cnt + 1'b1;
    end
  end

  // Shifter keeps its contents across disable (R10); no shift after last bit (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           sh <= '0;
    else if (take)                        sh <= tx_byte;
    else if (boundary && busy && !last)   sh <= lsb_first ? (sh >> 1) : (sh << 1);
  end

  // R7: mid-bit sampling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rx_sh <= '0;
    else if (midpoint && busy) rx_sh <= lsb_first ? {miso, rx_sh[W-1:1]}
                                                  : {rx_sh[W-2:0], miso};
  end

  assign mosi    = lsb_first ? sh[0] : sh[W-1];
  assign rx_word = rx_sh;
endmodule

// File: rtl/spi_buffers.sv
module spi_buffers #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  input  logic         take,
  output logic         tx_full,
  output logic [W-1:0] tx_byte,
  input  logic         finish,
  input  logic [W-1:0] rx_word,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  input  logic         stat_rd,
  output logic         spi_done
);
  logic accept;

  assign tx_ready = en && !tx_full;
  assign accept   = tx_valid && tx_ready;   // R9: nothing stored otherwise

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_full <= 1'b0;
    else if (!en)     tx_full <= 1'b0;
    else if (accept)  tx_full <= 1'b1;
    else if (take)    tx_full <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_byte <= '0;
    else if (accept) tx_byte <= tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rx_valid <= 1'b0;
    else if (!en)                  rx_valid <= 1'b0;
    else if (finish)               rx_valid <= 1'b1;
    else if (rx_valid && rx_ready) rx_valid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_data <= '0;
    else if (finish) rx_data <= rx_word;
  end

  // R8: completion wins over the status read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spi_done <= 1'b0;
    else if (!en)     spi_done <= 1'b0;
    else if (finish)  spi_done <= 1'b1;
    else if (stat_rd) spi_done <= 1'b0;
  end
endmodule

// File: rtl/spi_master_dbuf.sv
module spi_master_dbuf
  import spi_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  input  logic         stat_rd,
  output logic         spi_done,
  output logic         sclk,
  output logic         mosi,
  input  logic         miso
);
  half_t        half_q;
  logic         boundary;
  logic         midpoint;
  logic         first_half;
  logic         busy;
  logic         take;
  logic         finish;
  logic         tx_full;
  logic [W-1:0] tx_byte;
  logic [W-1:0] rx_word;

  spi_bitclk u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .half_q   (half_q),
    .boundary (boundary),
    .midpoint (midpoint)
  );

  spi_xfer_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .boundary  (boundary),
    .midpoint  (midpoint),
    .lsb_first (lsb_first),
    .miso      (miso),
    .tx_full   (tx_full),
    .tx_byte   (tx_byte),
    .busy      (busy),
    .take      (take),
    .finish    (finish),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  spi_buffers #(.W(W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .take     (take),
    .tx_full  (tx_full),
    .tx_byte  (tx_byte),
    .finish   (finish),
    .rx_word  (rx_word),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .stat_rd  (stat_rd),
    .spi_done (spi_done)
  );

  // R3: active half picked by cpha, level flipped by cpol
  assign first_half = (half_q == HALF_EARLY);
  assign sclk = cpol ^ (busy && (cpha ? first_half : !first_half));
endmodule

// File: rtl/spi_dbuf_checker.sv
module spi_dbuf_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cpol,
  input logic lsb_first,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic spi_done,
  input logic sclk,
  input logic mosi,
  input logic early
);
  assert_idle_sclk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !$past(enable)) |-> (sclk == cpol));

  assert_bit_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> (early != $past(early)));

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !early && $stable(lsb_first)) |-> $stable(mosi));

  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_done_with_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_done) |-> rx_valid);
endmodule

bind spi_master_dbuf spi_dbuf_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .cpol      (cpol),
  .lsb_first (lsb_first),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .spi_done  (spi_done),
  .sclk      (sclk),
  .mosi      (mosi),
  .early     (first_half)
);

// File: tb/spi_master_dbuf_tb.sv
module spi_master_dbuf_tb;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, enable, cpol, cpha, lsb_first;
  logic tx_valid, rx_ready, stat_rd;
  logic [W-1:0] tx_data;
  logic tx_ready, rx_valid, spi_done, sclk, mosi, miso;
  logic [W-1:0] rx_data;
  logic loop_en, miso_rand;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit finished = 0;
  int pulses[$];

  assign miso = loop_en ? mosi : miso_rand;

  always #(CLK_P/2) clk = ~clk;

  spi_master_dbuf #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .stat_rd(stat_rd), .spi_done(spi_done),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit m_ph, m_busy, m_txf, m_rxv, m_done;
  int m_idx;
  logic [W-1:0] m_sh, m_in, m_txb, m_rxb;

  always @(posedge clk) begin
    bit acc, rd, fin;
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_busy = 0; m_idx = 0; m_txf = 0; m_rxv = 0; m_done = 0;
      m_sh = '0; m_in = '0; m_txb = '0; m_rxb = '0;
    end else if (!enable) begin
      m_ph = 0; m_busy = 0; m_idx = 0; m_txf = 0; m_rxv = 0; m_done = 0;
    end else begin
      acc = tx_valid && !m_txf;
      rd  = m_rxv && rx_ready;
      fin = 0;
      if (m_ph) begin
        if (m_busy) m_in[lsb_first ? m_idx : (W-1-m_idx)] = miso;
      end else begin
        if (m_busy && m_idx == W-1) fin = 1;
        if (!m_busy || m_idx == W-1) begin
          if (m_txf) begin
            m_sh = m_txb; m_busy = 1; m_idx = 0; m_txf = 0;
          end else m_busy = 0;
        end else begin
          m_idx++;
          m_sh = lsb_first ? (m_sh >> 1) : (m_sh << 1);
        end
      end
      if (fin) begin m_rxb = m_in; m_rxv = 1; end
      else if (rd) m_rxv = 0;
      if (fin) m_done = 1;
      else if (stat_rd) m_done = 0;
      if (acc) begin m_txf = 1; m_txb = tx_data; end
      m_ph = !m_ph;
    end
  end

  // compare every clock, a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n && !finished) begin
      chk("R2/R3 sclk", sclk, cpol ^ (m_busy && (cpha ? m_ph : !m_ph)));
      chk("R4/R11 mosi", mosi, lsb_first ? m_sh[0] : m_sh[W-1]);
      chk("R5/R9 tx_ready", tx_ready, enable && !m_txf);
      chk("R7 rx_valid", rx_valid, m_rxv);
      chk("R7 rx_data", rx_data, m_rxb);
      chk("R8 spi_done", spi_done, m_done);
    end
  end

  always @(negedge clk) begin
    miso_rand <= 1'($urandom);
    if (rx_valid && rx_ready) pulses.push_back(cyc);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [W-1:0] b);
    while (1) begin
      @(negedge clk);
      if (tx_ready) break;
    end
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic status_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; cpol = 0; cpha = 0; lsb_first = 0;
    tx_valid = 0; tx_data = '0; rx_ready = 0; stat_rd = 0; loop_en = 0;
    tick(3);
    rst_n = 1;
    tick(1); #(CLK_P/4);
    chk("R1 reset sclk", sclk, 1'b0);
    chk("R1 reset mosi", mosi, 1'b0);
    chk("R1 reset tx_ready", tx_ready, 1'b0);
    chk("R1 reset rx_valid", rx_valid, 1'b0);
    chk("R1 reset spi_done", spi_done, 1'b0);

    // R9: offered while disabled has no effect
    @(negedge clk); tx_valid = 1; tx_data = 8'hEE;
    @(negedge clk); tx_valid = 0;

    // four modes, both bit orders, random MISO, chained bytes
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      enable = 0; cpol = m[1]; cpha = m[0]; lsb_first = (m == 1 || m == 2);
      tick(2);
      enable = 1; rx_ready = 1;
      pulses.delete();
      send(8'hA5 ^ 8'(m));
      send(8'h3C + 8'(m));
      send(8'h81);
      while (pulses.size() < 3) tick(1);
      chk("R6 chain gap 1", pulses[1] - pulses[0], 2 * W);
      chk("R6 chain gap 2", pulses[2] - pulses[1], 2 * W);
      tick(1);
      chk("R8 done set", spi_done, 1'b1);
      status_read();
      chk("R8 done cleared", spi_done, 1'b0);
      // single byte after idle: no chaining, idle lines
      send(8'h5E);
      tick(40);
      chk("R11 sclk idle", sclk, cpol);
    end

    // loopback, mode 0, MSb first
    @(negedge clk);
    enable = 0; cpol = 0; cpha = 0; lsb_first = 0; rx_ready = 0; loop_en = 1;
    tick(2);
    enable = 1;
    send(8'hC3);
    send(8'h97);
    @(negedge clk);
    chk("R9 ready low while full", tx_ready, 1'b0);
    tx_valid = 1; tx_data = 8'h0F;
    @(negedge clk); tx_valid = 0;
    tick(60);
    chk("R7 loopback byte", rx_data, 8'h97);
    chk("R9 no extra byte ready", tx_ready, 1'b1);
    chk("R11 sclk idle", sclk, 1'b0);
    chk("R11 mosi holds last bit", mosi, 1'b1);

    // R10: disable keeps data, clears flags
    @(negedge clk); enable = 0; cpol = 1;
    tick(2); #(CLK_P/4);
    chk("R10 rx_valid cleared", rx_valid, 1'b0);
    chk("R10 done cleared", spi_done, 1'b0);
    chk("R10 sclk idle", sclk, 1'b1);
    chk("R10 rx_data kept", rx_data, 8'h97);
    chk("R10 shifter kept msb", mosi, 1'b1);
    @(negedge clk); lsb_first = 1;
    #(CLK_P/4);
    chk("R1 lsb view of shifter", mosi, 1'b0);
    @(negedge clk); enable = 1; lsb_first = 0;
    tick(3);
    chk("R10 rx_data after re-enable", rx_data, 8'h97);

    // LSb-first loopback
    @(negedge clk); lsb_first = 1; cpha = 1;
    send(8'h2D);
    tick(40);
    chk("R4 lsb loopback", rx_data, 8'h2D);

    tick(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule